// File: doc/BRIEF.md
# Register-Selectable Cosine Oscillator

This block is a numerically controlled oscillator that produces a digital cosine for a current-output DAC. A 32-bit phase accumulator advances once per clock by a frequency tuning word. A 12-bit phase offset is added to the upper accumulator bits, and the sum addresses a cosine lookup. The output is a 10-bit offset-binary code.

Two tuning words and four phase offsets are preloaded through a parallel register-write port. A select input picks the active tuning word and a two-bit select input picks the active offset. Frequency and phase modulation therefore need only the select pins, with no reload of the registers. A power-down input freezes the accumulator and parks the output at mid-scale. The output frequency is `ftw * f_clk / 2^32`.

Top module: `tune_nco`

## Requirements
- R1: While `rst_i` is high at a rising edge, the accumulator, both tuning words, all four offsets and the address stage are cleared. After that edge `dac_o` reads 512.
- R2: Each rising edge without reset or power-down adds the selected tuning word to the accumulator, modulo 2^32. A tuning word N gives N / 2^32 output cycles per clock: 0x5671C71C at 6.25 MHz gives about 2.11 MHz.
- R3: `fsel_i` = 0 selects tuning word 0 and 1 selects tuning word 1. A change is used at the next edge and the accumulator keeps its value, so phase is continuous.
- R4: `psel_i` = k selects offset k (0..3). The offset is added modulo 4096 to accumulator bits [31:20], and the lookup address is bits [11:2] of that sum.
- R5: For lookup address a (0..1023), let c = cos(2*pi*(a+0.5)/1024). The code is 512 + floor(511.5*c) when c >= 0, and 511 - floor(-511.5*c) otherwise. 0 is most negative and 1023 most positive.
- R6: The code on `dac_o` after edge n comes from the accumulator value and the selected offset present just before edge n-1 (two registers from accumulator to output).
- R7: A write with `wr_en_i` high takes effect at the next edge. Address 0 loads tuning word 0 and address 1 loads tuning word 1 (all 32 bits). Addresses 2..5 load offsets 0..3 from bits [11:0], and bits [31:12] are ignored. Addresses 6 and 7 change nothing.
- R8: While `pd_i` is high at an edge, the accumulator holds and `dac_o` becomes 512 after that edge. When `pd_i` drops, the output resumes from the held phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pd_i | input | 1 | Power-down: hold phase, park output at mid-scale |
| fsel_i | input | 1 | Tuning word select |
| psel_i | input | 2 | Phase offset select |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| dac_o | output | 10 | Offset-binary cosine code |

## Verification
A register write is in place one edge after the strobe. A new tuning word reaches the accumulator at the edge after that and shows at the output two edges later. A select change on `psel_i` shows at the output after two edges, and power-down or reset parks the output after one edge. The bench drives inputs and samples outputs on the falling edge. Its cycle model of the accumulator and the two pipeline registers steps on every rising edge, so each compare is made against the code due for that exact edge. Directed latency checks count edges explicitly: the old code must persist after one edge and the new code must appear after the second.

// File: rtl/tnco_pkg.sv
package tnco_pkg;

   localparam real TNCO_PI = 3.14159265358979323846;

   // magnitude of the first quarter wave, half-sample phase offset
   function automatic int cos_mag(input int idx, input int aw, input int half);
      real amp;
      real ang;
      amp = real'(half) - 0.5;
      ang = 2.0 * TNCO_PI * (real'(idx) + 0.5) / real'(1 << aw);
      return $rtoi(amp * $cos(ang));
   endfunction

   // full offset-binary code for any address of the whole wave
   function automatic int cos_code(input int idx, input int aw, input int half);
      real amp;
      real c;
      amp = real'(half) - 0.5;
      c = $cos(2.0 * TNCO_PI * (real'(idx) + 0.5) / real'(1 << aw));
      if (c >= 0.0) return half + $rtoi(amp * c);
      return half - 1 - $rtoi(-amp * c);
   endfunction

endpackage

// File: rtl/tnco_regbank.sv
module tnco_regbank #(
   parameter int ACC_W     = 32,
   parameter int PH_W      = 12,
   parameter int NUM_FREQ  = 2,
   parameter int NUM_PHASE = 4,
   parameter int ADDR_W    = 3
) (
   input  logic                               clk_i,
   input  logic                               rst_i,
   input  logic                               wr_en_i,
   input  logic [ADDR_W-1:0]                  wr_addr_i,
   input  logic [ACC_W-1:0]                   wr_data_i,
   input  logic [$clog2(NUM_FREQ)-1:0]        fsel_i,
   input  logic [$clog2(NUM_PHASE)-1:0]       psel_i,
   output logic [NUM_FREQ-1:0][ACC_W-1:0]     freq_o,
   output logic [ACC_W-1:0]                   ftw_o,
   output logic [PH_W-1:0]                    poff_o
);

   logic [NUM_PHASE-1:0][PH_W-1:0] phase_w;

   initial begin : elab_chk
      assert (NUM_FREQ + NUM_PHASE <= (1 << ADDR_W))
         else $error("register map does not fit the address width");
      assert (PH_W <= ACC_W)
         else $error("offset wider than write data");
   end

   for (genvar g = 0; g < NUM_FREQ; g++) begin : g_freq
      logic [ACC_W-1:0] f_q;
      always_ff @(posedge clk_i) begin
         if (rst_i)
            f_q <= '0;
         else if (wr_en_i && wr_addr_i == ADDR_W'(g))
            f_q <= wr_data_i;
      end
      assign freq_o[g] = f_q;
   end

   for (genvar g = 0; g < NUM_PHASE; g++) begin : g_phase
      logic [PH_W-1:0] p_q;
      always_ff @(posedge clk_i) begin
         if (rst_i)
            p_q <= '0;
         else if (wr_en_i && wr_addr_i == ADDR_W'(NUM_FREQ + g))
            p_q <= wr_data_i[PH_W-1:0];
      end
      assign phase_w[g] = p_q;
   end

   assign ftw_o  = freq_o[fsel_i];
   assign poff_o = phase_w[psel_i];

endmodule

// File: rtl/tnco_phase_acc.sv
module tnco_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             hold_i,
   input  logic [ACC_W-1:0] ftw_i,
   output logic [ACC_W-1:0] acc_o
);

   always_ff @(posedge clk_i) begin
      if (rst_i)
         acc_o <= '0;
      else if (!hold_i)
         acc_o <= acc_o + ftw_i;
   end

endmodule

// File: rtl/tnco_phase_map.sv
module tnco_phase_map #(
   parameter int PH_W   = 12,
   parameter int LUT_AW = 10
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [PH_W-1:0]   acc_top_i,
   input  logic [PH_W-1:0]   poff_i,
   output logic [LUT_AW-1:0] addr_o
);

   localparam int DROP = PH_W - LUT_AW;

   initial begin : elab_chk
      assert (LUT_AW <= PH_W && LUT_AW >= 3)
         else $error("lookup address width out of range");
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)
         addr_o <= '0;
      else
         addr_o <= LUT_AW'((acc_top_i + poff_i) >> DROP);
   end

endmodule

// File: rtl/tnco_cos_lut.sv
module tnco_cos_lut #(
   parameter int LUT_AW       = 10,
   parameter int OUT_W        = 10,
   parameter bit QUARTER_WAVE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              park_i,
   input  logic [LUT_AW-1:0] addr_i,
   output logic [OUT_W-1:0]  code_o
);

   localparam int HALF = 1 << (OUT_W - 1);

   logic [OUT_W-1:0] code_d;

   initial begin : elab_chk
      assert (OUT_W >= 2 && OUT_W <= 24)
         else $error("output width out of range");
   end

   if (QUARTER_WAVE) begin : g_quarter
      localparam int QD = 1 << (LUT_AW - 2);
      logic [OUT_W-2:0] mag_rom [QD];
      logic [1:0]        quad;
      logic [LUT_AW-3:0] idx;
      logic [OUT_W-2:0]  mag;

      for (genvar g = 0; g < QD; g++) begin : g_rom
         localparam int MV = tnco_pkg::cos_mag(g, LUT_AW, HALF);
         assign mag_rom[g] = (OUT_W-1)'(MV);
      end

      always_comb begin
         quad = addr_i[LUT_AW-1:LUT_AW-2];
         idx  = quad[0] ? ~addr_i[LUT_AW-3:0] : addr_i[LUT_AW-3:0];
         mag  = mag_rom[idx];
         if (quad[1] ^ quad[0])
            code_d = OUT_W'(HALF - 1) - {1'b0, mag};
         else
            code_d = OUT_W'(HALF) + {1'b0, mag};
      end
   end else begin : g_full
      localparam int FD = 1 << LUT_AW;
      logic [OUT_W-1:0] code_rom [FD];

      for (genvar g = 0; g < FD; g++) begin : g_rom
         localparam int CV = tnco_pkg::cos_code(g, LUT_AW, HALF);
         assign code_rom[g] = OUT_W'(CV);
      end

      always_comb code_d = code_rom[addr_i];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i || park_i)
         code_o <= OUT_W'(HALF);
      else
         code_o <= code_d;
   end

endmodule

// File: rtl/tune_nco.sv
module tune_nco #(
   parameter int ACC_W        = 32,
   parameter int PH_W         = 12,
   parameter int LUT_AW       = 10,
   parameter int OUT_W        = 10,
   parameter int NUM_FREQ     = 2,
   parameter int NUM_PHASE    = 4,
   parameter int ADDR_W       = 3,
   parameter bit QUARTER_WAVE = 1'b1
) (
   input  logic                         clk_i,
   input  logic                         rst_i,
   input  logic                         pd_i,
   input  logic [$clog2(NUM_FREQ)-1:0]  fsel_i,
   input  logic [$clog2(NUM_PHASE)-1:0] psel_i,
   input  logic                         wr_en_i,
   input  logic [ADDR_W-1:0]            wr_addr_i,
   input  logic [ACC_W-1:0]             wr_data_i,
   output logic [OUT_W-1:0]             dac_o
);

   logic [NUM_FREQ-1:0][ACC_W-1:0] freq_q;
   logic [ACC_W-1:0]               ftw_sel;
   logic [PH_W-1:0]                poff_sel;
   logic [ACC_W-1:0]               acc_q;
   logic [LUT_AW-1:0]              lut_addr;

   initial begin : elab_chk
      assert (NUM_FREQ >= 2 && NUM_PHASE >= 2)
         else $error("at least two registers of each kind required");
      assert (PH_W <= ACC_W)
         else $error("offset wider than accumulator");
   end

   tnco_regbank #(
      .ACC_W(ACC_W), .PH_W(PH_W), .NUM_FREQ(NUM_FREQ),
      .NUM_PHASE(NUM_PHASE), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .fsel_i(fsel_i), .psel_i(psel_i),
      .freq_o(freq_q), .ftw_o(ftw_sel), .poff_o(poff_sel)
   );

   tnco_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk_i(clk_i), .rst_i(rst_i), .hold_i(pd_i),
      .ftw_i(ftw_sel), .acc_o(acc_q)
   );

   tnco_phase_map #(.PH_W(PH_W), .LUT_AW(LUT_AW)) u_map (
      .clk_i(clk_i), .rst_i(rst_i),
      .acc_top_i(acc_q[ACC_W-1 -: PH_W]), .poff_i(poff_sel),
      .addr_o(lut_addr)
   );

   tnco_cos_lut #(
      .LUT_AW(LUT_AW), .OUT_W(OUT_W), .QUARTER_WAVE(QUARTER_WAVE)
   ) u_lut (
      .clk_i(clk_i), .rst_i(rst_i), .park_i(pd_i),
      .addr_i(lut_addr), .code_o(dac_o)
   );

endmodule

// File: rtl/tune_nco_chk.sv
module tune_nco_chk #(
   parameter int ACC_W  = 32,
   parameter int OUT_W  = 10,
   parameter int ADDR_W = 3
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              pd_i,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic [ACC_W-1:0]  wr_data_i,
   input logic [ACC_W-1:0]  acc_q,
   input logic [ACC_W-1:0]  ftw_sel,
   input logic [ACC_W-1:0]  freq0,
   input logic [OUT_W-1:0]  dac_o
);

   localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));

   // R1
   reset_mid_chk: assert property (@(posedge clk_i) rst_i |=> dac_o == MID);

   // R2
   acc_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !pd_i |=> acc_q == $past(acc_q) + $past(ftw_sel));

   // R8
   pd_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      pd_i |=> acc_q == $past(acc_q));

   // R8
   pd_mid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      pd_i |=> dac_o == MID);

   // R7
   freq0_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_en_i && wr_addr_i == '0) |=> freq0 == $past(wr_data_i));

endmodule

bind tune_nco tune_nco_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .pd_i(pd_i), .wr_en_i(wr_en_i),
   .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .acc_q(acc_q),
   .ftw_sel(ftw_sel), .freq0(freq_q[0]), .dac_o(dac_o)
);

// File: tb/tune_nco_test.sv
module tune_nco_test;

   localparam real PI = 3.14159265358979323846;

   typedef struct packed {
      logic [31:0] data;
      logic [1:0]  sel;
      logic [9:0]  exp;
   } vec_t;

   // offset value, offset register, expected code with zero accumulator
   localparam vec_t VECS [10] = '{
      '{32'h0000_0000, 2'd0, 10'd1023},
      '{32'h0000_0400, 2'd1, 10'd510},
      '{32'h0000_0800, 2'd2, 10'd0},
      '{32'h0000_0C00, 2'd3, 10'd513},
      '{32'h0000_03FC, 2'd0, 10'd513},
      '{32'h0000_07FC, 2'd1, 10'd0},
      '{32'h0000_0BFC, 2'd2, 10'd510},
      '{32'h0000_0FFC, 2'd3, 10'd1023},
      '{32'h0000_0200, 2'd1, 10'd872},
      '{32'hFFFF_F800, 2'd2, 10'd0}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        pd = 1'b0;
   logic        fsel = 1'b0;
   logic [1:0]  psel = 2'd0;
   logic        wr = 1'b0;
   logic [2:0]  waddr = 3'd0;
   logic [31:0] wdata = 32'd0;
   logic [9:0]  dac;

   int n_run = 0;
   int n_fail = 0;

   logic [31:0] m_acc;
   logic [31:0] m_f [2];
   logic [11:0] m_p [4];
   logic [9:0]  m_s1;
   logic [9:0]  m_out;

   tune_nco uut (
      .clk_i(clk), .rst_i(rst), .pd_i(pd), .fsel_i(fsel), .psel_i(psel),
      .wr_en_i(wr), .wr_addr_i(waddr), .wr_data_i(wdata), .dac_o(dac)
   );

   always #4 clk = ~clk;

   function automatic logic [9:0] cos_ref(input logic [9:0] a);
      real c;
      c = $cos(2.0 * PI * (real'(a) + 0.5) / 1024.0);
      if (c >= 0.0) return 10'(512 + $rtoi(511.5 * c));
      return 10'(511 - $rtoi(-511.5 * c));
   endfunction

   task automatic step();
      logic [9:0]  n_out;
      logic [9:0]  n_s1;
      logic [11:0] sum;
      @(posedge clk);
      if (rst) begin
         m_acc = '0; m_s1 = '0; m_out = 10'd512;
         m_f[0] = '0; m_f[1] = '0;
         for (int k = 0; k < 4; k++) m_p[k] = '0;
      end else begin
         n_out = pd ? 10'd512 : cos_ref(m_s1);
         sum   = m_acc[31:20] + m_p[psel];
         n_s1  = sum[11:2];
         if (!pd) m_acc = m_acc + m_f[fsel];
         m_s1  = n_s1;
         m_out = n_out;
         if (wr) begin
            if (waddr < 3'd2) m_f[waddr[0]] = wdata;
            else if (waddr < 3'd6) m_p[2'(waddr - 3'd2)] = wdata[11:0];
         end
      end
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
      wr = 1'b1; waddr = a; wdata = d;
      step();
      wr = 1'b0; wdata = 32'd0;
   endtask

   task automatic run_cmp(input string req, input int n);
      int bad = 0;
      int ba = 0;
      int be = 0;
      for (int i = 0; i < n; i++) begin
         step();
         if (dac !== m_out) begin
            if (bad == 0) begin ba = int'(dac); be = int'(m_out); end
            bad++;
         end
      end
      n_run++;
      if (bad != 0) begin
         n_fail++;
         $display("FAIL %s: %0d cycle mismatches, first got %0d expected %0d",
                  req, bad, ba, be);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; pd = 1'b0; fsel = 1'b0; psel = 2'd0; wr = 1'b0;
      step(); step();
      rst = 1'b0;
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int crossings;
      logic prev_msb;
      longint unsigned turns;

      @(negedge clk);
      do_reset();
      // R1 reset state parks at mid-scale
      chk("R1 reset output", int'(dac), 512);
      chk("R1 reset model", int'(dac), int'(m_out));

      // R4 R5 R7 table walk: accumulator stays zero, offsets vary
      for (int v = 0; v < 10; v++) begin
         write_reg(3'(2 + VECS[v].sel), VECS[v].data);
         psel = VECS[v].sel;
         step(); step(); step();
         chk($sformatf("R5 R4 vector %0d", v), int'(dac), int'(VECS[v].exp));
      end

      // R6 latency: old code survives one edge, new code after two
      write_reg(3'd2, 32'h0);
      write_reg(3'd3, 32'h800);
      psel = 2'd0;
      step(); step(); step();
      chk("R6 settle", int'(dac), 1023);
      psel = 2'd1;
      step();
      chk("R6 one edge", int'(dac), 1023);
      step();
      chk("R6 two edges", int'(dac), 0);

      // R2 running accumulator against cycle model
      psel = 2'd0;
      write_reg(3'd0, 32'h0100_0000);
      run_cmp("R2 R6 sweep", 300);

      // R3 frequency switching
      write_reg(3'd1, 32'h0040_0000);
      for (int k = 0; k < 8; k++) begin
         fsel = ~fsel;
         run_cmp("R3 fsel switch", 7);
      end
      fsel = 1'b0;

      // R4 offset switching on a running phase
      write_reg(3'd4, 32'h0000_0555);
      write_reg(3'd5, 32'h0000_0AAA);
      for (int k = 0; k < 4; k++) begin
         psel = 2'(k);
         run_cmp("R4 psel switch", 5);
      end

      // R8 power-down: parks at 512, phase held, resumes from held phase
      pd = 1'b1;
      step();
      chk("R8 parked", int'(dac), 512);
      for (int k = 0; k < 10; k++) step();
      chk("R8 still parked", int'(dac), 512);
      pd = 1'b0;
      run_cmp("R8 resume", 40);

      // R7 writes to addresses 6 and 7 change nothing
      write_reg(3'd6, 32'hFFFF_FFFF);
      write_reg(3'd7, 32'h1234_5678);
      run_cmp("R7 unused address", 60);

      // R1 reset mid-run clears everything again
      rst = 1'b1;
      step();
      chk("R1 mid-run reset", int'(dac), 512);
      step();
      rst = 1'b0;
      step(); step();
      chk("R1 cleared phase", int'(dac), 1023);

      // R2 output frequency: 0x5671C71C at 6.25 MHz gives about 2.11 MHz
      write_reg(3'd0, 32'h5671_C71C);
      fsel = 1'b0; psel = 2'd0;
      step(); step(); step();
      crossings = 0;
      prev_msb = dac[9];
      for (int k = 0; k < 4096; k++) begin
         step();
         if (!prev_msb && dac[9]) crossings++;
         prev_msb = dac[9];
      end
      turns = (longint'(4096) * longint'(32'h5671_C71C)) >> 32;
      $display("[TB] estimated output %0.3f MHz", real'(crossings) * 6.25 / 4096.0);
      n_run++;
      if (crossings < int'(turns) - 1 || crossings > int'(turns) + 1) begin
         n_fail++;
         $display("FAIL R2 frequency: got %0d expected %0d", crossings, int'(turns));
      end
      run_cmp("R2 fast tuning word", 200);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule